// File: doc/BRIEF.md
# Polyphase Scaler Setup Calculator

This block works out the setup words a polyphase video upscaler needs for one plane. A request gives a source width and height and a destination width and height, each an unsigned 13-bit count. The block returns four results per axis. The first is the scale ratio in unsigned 16.16 fixed point. The second is a 3-bit code that picks one of five filter coefficient banks. The third is the starting phase offset and the fourth is the per-output-pixel phase step.

One restoring divider does all six divisions in turn, one quotient bit per clock. The order is horizontal ratio, vertical ratio, horizontal initial phase, horizontal step, vertical initial phase, vertical step. If either axis would shrink the image, the block stops after the two ratios and raises its error output. If any size is zero, it stops at once without dividing. A one-cycle done pulse ends every request. The results then stay unchanged until a new request is accepted.

Top module: `scl_phase_calc`

## Requirements
- R1: The ratio output of each axis equals floor((destination << 16) / source), where destination and source are the sizes on that axis.
- R2: If bit field [31:16] of either ratio is zero, then at done error_o=1 and scale_en_o=0. The ratios and codes still reflect both axes, and all four phase outputs read 0.
- R3: The initial phase of each axis equals (floor((source << 4) / destination) + 1) >> 1.
- R4: The phase step of each axis equals floor((source << 16) / destination).
- R5: A ratio of 0x10000 or more gives coefficient code 1.
- R6: Below 0x10000, the code is 2 if the ratio is at least 0xAAAA, 3 if at least 0x8000, 4 if at least 0x5D17, and 5 otherwise. The codes follow the stored ratios at all times, including in the error case.
- R7: When no axis shrinks and no size is zero, done comes with error_o=0 and scale_en_o=1.
- R8: done_o is high for exactly one cycle per accepted request. busy_o is high from the cycle after acceptance through the done cycle, and is low in the cycle after done.
- R9: If any of the four sizes is zero when a request is accepted, then in the next cycle done_o=1 and error_o=1. All ratio and phase outputs read 0, both codes read 5, and scale_en_o=0.
- R10: A start seen while busy_o=1, including in the done cycle, is ignored. Results hold their values until the next accepted start.
- R11: After reset, busy_o, done_o, error_o and scale_en_o are 0, all ratio and phase outputs are 0, and both codes are 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request; accepted only while idle |
| src_w_i | input | 13 | Source width |
| src_h_i | input | 13 | Source height |
| dst_w_i | input | 13 | Destination width |
| dst_h_i | input | 13 | Destination height |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Zero size or shrinking axis |
| scale_en_o | output | 1 | Results valid for upscaling |
| h_ratio_o | output | 32 | Horizontal ratio, U16.16 |
| v_ratio_o | output | 32 | Vertical ratio, U16.16 |
| h_code_o | output | 3 | Horizontal coefficient bank code |
| v_code_o | output | 3 | Vertical coefficient bank code |
| h_init_o | output | 32 | Horizontal initial phase |
| h_delta_o | output | 32 | Horizontal phase step |
| v_init_o | output | 32 | Vertical initial phase |
| v_delta_o | output | 32 | Vertical phase step |

## Verification
The done pulse and a new start request can land in the same cycle. The done cycle still counts as busy, so that start must be dropped. To provoke this, the bench raises start with different sizes in the exact cycle where it sees done, and also at several points mid-run. It then checks that busy falls in the next cycle, that no new run begins, and that every result still matches the first request. A second overlap comes from the downscale decision, which is taken in the same cycle as the vertical ratio is stored. Cases with exactly one shrinking axis show whether the error is raised from the freshly computed quotient rather than from the stale stored ratio.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int RATIO_W = 32;
  localparam int CODE_W  = 3;
  localparam int FRAC_W  = 16;
  localparam int PHASE_SHIFT = 4;

  localparam logic [RATIO_W-1:0] TH_UNITY = 32'h0001_0000;
  localparam logic [RATIO_W-1:0] TH_B2    = 32'h0000_AAAA;
  localparam logic [RATIO_W-1:0] TH_B3    = 32'h0000_8000;
  localparam logic [RATIO_W-1:0] TH_B4    = 32'h0000_5D17;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT, ST_FINISH} scl_state_e;

  typedef enum logic [2:0] {
    OP_H_RATIO, OP_V_RATIO, OP_H_INIT, OP_H_STEP, OP_V_INIT, OP_V_STEP
  } scl_op_e;

  function automatic logic [CODE_W-1:0] pick_bank(input logic [RATIO_W-1:0] r);
    if (r >= TH_UNITY)   return 3'd1;
    else if (r >= TH_B2) return 3'd2;
    else if (r >= TH_B3) return 3'd3;
    else if (r >= TH_B4) return 3'd4;
    else                 return 3'd5;
  endfunction

  function automatic logic [RATIO_W-1:0] round_half(input logic [RATIO_W-1:0] q);
    return (q + 1'b1) >> 1;
  endfunction
endpackage

// File: rtl/scl_div.sv
module scl_div #(
  parameter int DW = 32,
  parameter int SW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [SW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o
);
  localparam int CW = $clog2(DW);

  logic [DW-1:0] acc_q, orig_q;
  logic [SW-1:0] rem_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [SW:0]   rem_sh, diff;
  logic          fits;
  logic [SW-1:0] rem_nx;

  always_comb begin
    rem_sh = {rem_q, acc_q[DW-1]};
    fits   = rem_sh >= {1'b0, dsr_q};
    diff   = rem_sh - {1'b0, dsr_q};
    rem_nx = fits ? diff[SW-1:0] : rem_sh[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      orig_q <= '0;
      rem_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        acc_q  <= dividend_i;
        orig_q <= dividend_i;
        dsr_q  <= divisor_i;
        rem_q  <= '0;
        cnt_q  <= '0;
        run_q  <= 1'b1;
      end else if (run_q) begin
        acc_q <= {acc_q[DW-2:0], fits};
        rem_q <= rem_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(DW-1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = acc_q;

  // R1, R3, R4: quotient times divisor plus remainder rebuilds the dividend
  assert_div_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((64'(acc_q) * 64'(dsr_q) + 64'(rem_q)) == 64'(orig_q)) && (rem_q < dsr_q));
endmodule

// File: rtl/scl_code_sel.sv
module scl_code_sel
  import scl_pkg::*;
(
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [CODE_W-1:0]  code_o
);
  always_comb code_o = pick_bank(ratio_i);
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
  import scl_pkg::*;
#(
  parameter int SZW = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [12:0] src_w_i,
  input  logic [12:0] src_h_i,
  input  logic [12:0] dst_w_i,
  input  logic [12:0] dst_h_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        error_o,
  output logic        scale_en_o,
  output logic [31:0] h_ratio_o,
  output logic [31:0] v_ratio_o,
  output logic [2:0]  h_code_o,
  output logic [2:0]  v_code_o,
  output logic [31:0] h_init_o,
  output logic [31:0] h_delta_o,
  output logic [31:0] v_init_o,
  output logic [31:0] v_delta_o
);
  localparam int DIVW  = RATIO_W;
  localparam int NAXIS = 2;

  scl_state_e    state_q;
  scl_op_e       op_q;
  logic [SZW-1:0] sw_q, sh_q, dw_q, dh_q;
  logic [DIVW-1:0] ratio_q [NAXIS];
  logic [DIVW-1:0] init_q  [NAXIS];
  logic [DIVW-1:0] step_q  [NAXIS];
  logic [CODE_W-1:0] code_w [NAXIS];
  logic err_q, en_q;

  logic            div_start, div_done;
  logic [DIVW-1:0] div_dvd, div_quot;
  logic [SZW-1:0]  div_dsr;
  logic            zero_req, accept, downscale_hit;

  assign accept        = (state_q == ST_IDLE) && start_i;
  assign zero_req      = (src_w_i == '0) || (src_h_i == '0) || (dst_w_i == '0) || (dst_h_i == '0);
  assign div_start     = (state_q == ST_LAUNCH);
  assign downscale_hit = (ratio_q[0][DIVW-1:FRAC_W] == '0) || (div_quot[DIVW-1:FRAC_W] == '0);

  always_comb begin
    div_dvd = '0;
    div_dsr = sw_q;
    unique case (op_q)
      OP_H_RATIO: begin div_dvd = DIVW'({dw_q, 16'b0}); div_dsr = sw_q; end
      OP_V_RATIO: begin div_dvd = DIVW'({dh_q, 16'b0}); div_dsr = sh_q; end
      OP_H_INIT:  begin div_dvd = DIVW'({sw_q, 4'b0});  div_dsr = dw_q; end
      OP_H_STEP:  begin div_dvd = DIVW'({sw_q, 16'b0}); div_dsr = dw_q; end
      OP_V_INIT:  begin div_dvd = DIVW'({sh_q, 4'b0});  div_dsr = dh_q; end
      default:    begin div_dvd = DIVW'({sh_q, 16'b0}); div_dsr = dh_q; end
    endcase
  end

  scl_div #(.DW(DIVW), .SW(SZW)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (div_dvd),
    .divisor_i  (div_dsr),
    .done_o     (div_done),
    .quot_o     (div_quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_H_RATIO;
      {sw_q, sh_q, dw_q, dh_q} <= '0;
      for (int a = 0; a < NAXIS; a++) begin
        ratio_q[a] <= '0;
        init_q[a]  <= '0;
        step_q[a]  <= '0;
      end
      err_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sw_q <= src_w_i;
          sh_q <= src_h_i;
          dw_q <= dst_w_i;
          dh_q <= dst_h_i;
          for (int a = 0; a < NAXIS; a++) begin
            ratio_q[a] <= '0;
            init_q[a]  <= '0;
            step_q[a]  <= '0;
          end
          en_q  <= 1'b0;
          op_q  <= OP_H_RATIO;
          err_q <= zero_req;
          state_q <= zero_req ? ST_FINISH : ST_LAUNCH;
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          unique case (op_q)
            OP_H_RATIO: ratio_q[0] <= div_quot;
            OP_V_RATIO: ratio_q[1] <= div_quot;
            OP_H_INIT:  init_q[0]  <= round_half(div_quot);
            OP_H_STEP:  step_q[0]  <= div_quot;
            OP_V_INIT:  init_q[1]  <= round_half(div_quot);
            default:    step_q[1]  <= div_quot;
          endcase
          if (op_q == OP_V_RATIO && downscale_hit) begin
            err_q   <= 1'b1;
            state_q <= ST_FINISH;
          end else if (op_q == OP_V_STEP) begin
            en_q    <= 1'b1;
            state_q <= ST_FINISH;
          end else begin
            op_q    <= scl_op_e'(op_q + 3'd1);
            state_q <= ST_LAUNCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NAXIS; g++) begin : g_axis
    scl_code_sel u_code (.ratio_i(ratio_q[g]), .code_o(code_w[g]));

    // R5: unity-or-above ratio selects the upscale bank
    assert_bank_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_q[g] >= TH_UNITY) |-> (code_w[g] == 3'd1));
    // R6: ratios below the lowest threshold select bank 5
    assert_bank_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_q[g] < TH_B4) |-> (code_w[g] == 3'd5));
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FINISH);
  assign error_o    = err_q;
  assign scale_en_o = en_q;
  assign h_ratio_o  = ratio_q[0];
  assign v_ratio_o  = ratio_q[1];
  assign h_code_o   = code_w[0];
  assign v_code_o   = code_w[1];
  assign h_init_o   = init_q[0];
  assign v_init_o   = init_q[1];
  assign h_delta_o  = step_q[0];
  assign v_delta_o  = step_q[1];

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (error_o != scale_en_o));
  assert_shrink_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && (h_ratio_o[31:16] == '0 || v_ratio_o[31:16] == '0)) |-> error_o && (h_init_o == '0));
  assert_zero_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && zero_req) |=> done_o && error_o);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || !start_i) |=> $stable(sw_q) && $stable(dh_q));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(h_ratio_o) && $stable(v_delta_o) && $stable(error_o));
endmodule

// File: tb/scl_phase_calc_bench.sv
module scl_phase_calc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [12:0] src_w_i = '0, src_h_i = '0, dst_w_i = '0, dst_h_i = '0;
  logic        busy_o, done_o, error_o, scale_en_o;
  logic [31:0] h_ratio_o, v_ratio_o, h_init_o, h_delta_o, v_init_o, v_delta_o;
  logic [2:0]  h_code_o, v_code_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  scl_phase_calc u_scl_phase_calc (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .src_w_i(src_w_i), .src_h_i(src_h_i), .dst_w_i(dst_w_i), .dst_h_i(dst_h_i),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .scale_en_o(scale_en_o),
    .h_ratio_o(h_ratio_o), .v_ratio_o(v_ratio_o), .h_code_o(h_code_o), .v_code_o(v_code_o),
    .h_init_o(h_init_o), .h_delta_o(h_delta_o), .v_init_o(v_init_o), .v_delta_o(v_delta_o)
  );

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint unsigned m_ratio(input int s, input int d);
    return (longint'(d) * 65536) / s;
  endfunction

  function automatic longint unsigned m_init(input int s, input int d);
    longint unsigned q = (longint'(s) * 16) / d;
    return (q + 1) / 2;
  endfunction

  function automatic int m_code(input longint unsigned r);
    longint unsigned lims[4] = '{65536, 43690, 32768, 23831};
    for (int k = 0; k < 4; k++) if (r >= lims[k]) return k + 1;
    return 5;
  endfunction

  task automatic check_outputs(input int sw, input int sh, input int dw, input int dh);
    longint unsigned rh, rv;
    bit zero, shrink;
    zero = (sw == 0) || (sh == 0) || (dw == 0) || (dh == 0);
    rh = zero ? 0 : m_ratio(sw, dw);
    rv = zero ? 0 : m_ratio(sh, dh);
    shrink = !zero && ((rh < 65536) || (rv < 65536));
    if (zero) begin
      chk("R9 error", error_o, 1);
      chk("R9 h_ratio", h_ratio_o, 0);
      chk("R9 v_code", v_code_o, 5);
    end else begin
      chk("R1 h_ratio", h_ratio_o, rh);
      chk("R1 v_ratio", v_ratio_o, rv);
      chk("R5/R6 h_code", h_code_o, m_code(rh));
      chk("R5/R6 v_code", v_code_o, m_code(rv));
    end
    if (zero || shrink) begin
      chk("R2 error", error_o, 1);
      chk("R2 scale_en", scale_en_o, 0);
      chk("R2 phases zero", h_init_o | h_delta_o | v_init_o | v_delta_o, 0);
    end else begin
      chk("R7 error", error_o, 0);
      chk("R7 scale_en", scale_en_o, 1);
      chk("R3 h_init", h_init_o, m_init(sw, dw));
      chk("R3 v_init", v_init_o, m_init(sh, dh));
      chk("R4 h_delta", h_delta_o, m_ratio(dw, sw));
      chk("R4 v_delta", v_delta_o, m_ratio(dh, sh));
    end
  endtask

  // poke: nonzero means drive a competing start with other sizes while busy
  task automatic run(input int sw, input int sh, input int dw, input int dh, input bit poke);
    int cyc = 1;
    @(negedge clk);
    src_w_i = 13'(sw); src_h_i = 13'(sh); dst_w_i = 13'(dw); dst_h_i = 13'(dh);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 busy after accept", busy_o, 1);
    while (!done_o && cyc < 400) begin
      if (poke && (cyc % 37 == 5)) begin
        src_w_i = 13'd3; dst_w_i = 13'd1; start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk("R8 done seen", done_o, 1);
    if (sw == 0 || sh == 0 || dw == 0 || dh == 0) chk("R9 done next cycle", cyc, 1);
    chk("R8 busy in done cycle", busy_o, 1);
    check_outputs(sw, sh, dw, dh);
    if (poke) begin
      src_w_i = 13'd7; src_h_i = 13'd0; start_i = 1'b1;
    end
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 done single cycle", done_o, 0);
    chk("R10 busy low after done", busy_o, 0);
    @(negedge clk);
    chk("R10 still idle", busy_o, 0);
    check_outputs(sw, sh, dw, dh);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R11 busy", busy_o, 0);
    chk("R11 done", done_o, 0);
    chk("R11 error", error_o, 0);
    chk("R11 scale_en", scale_en_o, 0);
    chk("R11 ratios", h_ratio_o | v_ratio_o, 0);
    chk("R11 codes", {h_code_o, v_code_o}, {3'd5, 3'd5});
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(100, 100, 100, 100, 0);     // exactly unity, R5
    run(3, 2, 2, 1, 0);             // 0xAAAA and 0x8000, R6
    run(11, 4, 4, 1, 0);            // 0x5D17 and 0x4000, R6
    run(1, 1, 8191, 8191, 0);       // largest ratio
    run(8191, 8191, 8191, 8191, 0);
    run(640, 480, 1920, 479, 0);    // only vertical shrinks, R2
    run(641, 480, 640, 1080, 0);    // only horizontal shrinks, R2
    run(0, 10, 20, 30, 0);          // zero source, R9
    run(10, 10, 20, 0, 0);          // zero destination, R9
    run(320, 240, 1280, 720, 1);    // competing starts, R10
    for (int i = 0; i < 20; i++) begin
      int sw = 1 + int'($urandom % 8191);
      int sh = 1 + int'($urandom % 8191);
      run(sw, sh, 1 + int'($urandom % 8191), 1 + int'($urandom % 8191), i[0]);
    end
    for (int i = 0; i < 25; i++) begin
      int sw = 1 + int'($urandom % 4095);
      int sh = 1 + int'($urandom % 4095);
      int dw = sw + int'($urandom % (8192 - sw));
      int dh = sh + int'($urandom % (8192 - sh));
      run(sw, sh, dw, dh, i[1]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule